// File: doc/BRIEF.md
# General-Call Software Reset Detector

This block sits behind the byte-level receiver of a two-wire serial slave in a port-expander. It watches the start, stop, address-byte and data-byte events that the receiver reports and picks out the general-call write that carries the software-reset code. For every address or data byte it sees, it returns one acknowledge decision. This lets the bit-level engine drive the acknowledge slot without knowing anything about the general-call rules.

When a general-call write holds exactly one accepted reset-code byte and then ends with a stop, the block raises a one-cycle reset pulse. The expander uses that pulse to put every register back to its power-on default, which also makes every pin an input. A repeated start, a wrong code or an extra data byte cancels the reset. Every start or stop condition returns the sequencer to idle.

The address byte is taken as a 7-bit address in bits 7..1 with the read/write flag in bit 0, where 0 means write. The general-call address and the reset code are parameters whose defaults are 0x00 and 0x06.

Top module: `gcr_swreset_det`

## Requirements
- R1: While `rst_n` is low, and in the first sampled cycle after its release, `ack_valid_o`, `ack_o` and `swrst_o` are 0. A reset taken after a reset code was accepted cancels the pending pulse: a later stop gives no pulse.
- R2: An address byte of 0x00 (general-call address 0, R/W bit 0 = 0) seen directly after a start is acknowledged. In the cycle after the strobe, `ack_valid_o` = 1 and `ack_o` = 1.
- R3: Any other address byte is not acknowledged (`ack_valid_o` = 1, `ack_o` = 0). This includes 0x01, the general call with R/W = 1. Data bytes that follow such an address are also not acknowledged.
- R4: The first data byte after an acknowledged general-call address is acknowledged when it equals 0x06.
- R5: A first data byte other than 0x06 is not acknowledged, and the stop that follows gives no reset pulse.
- R6: Any data byte after an accepted 0x06 is not acknowledged and cancels the pending reset, so the following stop gives no pulse.
- R7: A stop after exactly one accepted 0x06 byte sets `swrst_o` to 1 for exactly one cycle, in the cycle after the stop strobe.
- R8: A repeated start after an accepted 0x06 byte cancels the reset. A complete new general-call reset sequence that follows it still produces the pulse.
- R9: A start or stop in the same cycle as a byte strobe takes precedence, and the byte gets no decision (`ack_valid_o` stays 0). An address byte that arrives without a preceding start, after a stop, is not acknowledged.
- R10: `ack_valid_o` is 1 only in the cycle after a byte strobe, and `ack_o` is 1 only while `ack_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start or repeated-start condition seen (one-cycle strobe) |
| stop_i | input | 1 | Stop condition seen (one-cycle strobe) |
| addr_v_i | input | 1 | Address byte received (one-cycle strobe) |
| addr_i | input | BYTE_W | Received address byte: address in bits 7..1, R/W in bit 0 |
| data_v_i | input | 1 | Data byte received (one-cycle strobe) |
| data_i | input | BYTE_W | Received data byte |
| ack_valid_o | output | 1 | Acknowledge decision valid for the last byte |
| ack_o | output | 1 | 1 = acknowledge, 0 = not acknowledge |
| swrst_o | output | 1 | One-cycle software-reset pulse |

## Verification
The bench builds the block with its defaults: 8-bit bytes, general-call address 0 and reset code 0x06. These are exactly the values for which the accept and refuse paths can be driven with literal bytes, including the near-miss codes 0x07 and 0x01. With these defaults, one vector walk covers a good reset, a read-flagged general call, a wrong code, a double code, a repeated start and a foreign address. Directed steps then reach a strobe that collides with a start, an address with no start, and a reset taken while the pulse is armed.

// File: rtl/gcr_pkg.sv
package gcr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_DATA  = 3'd2,
    ST_ARMED = 3'd3,
    ST_DEAD  = 3'd4
  } gcr_state_e;
endpackage

// File: rtl/gcr_addr_match.sv
module gcr_addr_match #(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned GC_ADDR = 0
) (
  input  logic [BYTE_W-1:0] byte_i,
  output logic              gc_wr_o
);
  localparam int unsigned AW = BYTE_W - 1;
  localparam logic [AW-1:0] GC_VAL = AW'(GC_ADDR);

  // address lives above the R/W flag; only the write form qualifies
  always_comb begin
    gc_wr_o = (byte_i[BYTE_W-1:1] == GC_VAL) && !byte_i[0];
  end
endmodule

// File: rtl/gcr_code_match.sv
module gcr_code_match #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CODE   = 6
) (
  input  logic [BYTE_W-1:0] byte_i,
  output logic              hit_o
);
  localparam logic [BYTE_W-1:0] CODE_VAL = BYTE_W'(CODE);

  always_comb begin
    hit_o = (byte_i == CODE_VAL);
  end
endmodule

// File: rtl/gcr_seq.sv
module gcr_seq
  import gcr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic addr_v_i,
  input  logic data_v_i,
  input  logic gc_wr_i,
  input  logic code_ok_i,
  output logic ack_valid_o,
  output logic ack_o,
  output logic swrst_o
);
  gcr_state_e st_q, st_d;
  logic       st_en;
  logic       ackv_d, ack_d, swrst_d;

  // next-state and decision logic; stop outranks start, both outrank bytes
  always_comb begin
    st_d    = st_q;
    ackv_d  = 1'b0;
    ack_d   = 1'b0;
    swrst_d = 1'b0;
    if (stop_i) begin
      st_d    = ST_IDLE;
      swrst_d = (st_q == ST_ARMED);
    end else if (start_i) begin
      st_d = ST_ADDR;
    end else if (addr_v_i) begin
      ackv_d = 1'b1;
      if ((st_q == ST_ADDR) && gc_wr_i) begin
        ack_d = 1'b1;
        st_d  = ST_DATA;
      end else begin
        st_d = ST_DEAD;
      end
    end else if (data_v_i) begin
      ackv_d = 1'b1;
      if ((st_q == ST_DATA) && code_ok_i) begin
        ack_d = 1'b1;
        st_d  = ST_ARMED;
      end else begin
        st_d = ST_DEAD;
      end
    end
  end

  assign st_en = stop_i | start_i | addr_v_i | data_v_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid_o <= 1'b0;
      ack_o       <= 1'b0;
      swrst_o     <= 1'b0;
    end else begin
      ack_valid_o <= ackv_d;
      ack_o       <= ack_d;
      swrst_o     <= swrst_d;
    end
  end

  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_o |=> !swrst_o);
  p_pulse_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_o |-> ($past(stop_i) && ($past(st_q) == ST_ARMED)));
  p_ack_in_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> ack_valid_o);
  p_ackv_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid_o |-> ($past(addr_v_i || data_v_i) && !$past(start_i || stop_i)));
  p_data_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && $past(data_v_i)) |-> $past(code_ok_i));
  p_addr_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && $past(addr_v_i)) |-> ($past(gc_wr_i) && ($past(st_q) == ST_ADDR)));
endmodule

// File: rtl/gcr_swreset_det.sv
module gcr_swreset_det #(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned GC_ADDR = 0,
  parameter int unsigned CODE    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              addr_v_i,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic              data_v_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              ack_valid_o,
  output logic              ack_o,
  output logic              swrst_o
);
  logic gc_wr, code_ok;

  gcr_addr_match #(.BYTE_W(BYTE_W), .GC_ADDR(GC_ADDR)) u_addr (
    .byte_i (addr_i),
    .gc_wr_o(gc_wr)
  );

  gcr_code_match #(.BYTE_W(BYTE_W), .CODE(CODE)) u_code (
    .byte_i(data_i),
    .hit_o (code_ok)
  );

  gcr_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .addr_v_i   (addr_v_i),
    .data_v_i   (data_v_i),
    .gc_wr_i    (gc_wr),
    .code_ok_i  (code_ok),
    .ack_valid_o(ack_valid_o),
    .ack_o      (ack_o),
    .swrst_o    (swrst_o)
  );
endmodule

// File: tb/sim_gcr_swreset_det.sv
module sim_gcr_swreset_det;
  // vector: kind[13:11] byte[10:3] exp ackv[2] ack[1] rst[0]
  // kinds: 0 idle, 1 start, 2 stop, 3 address, 4 data
  localparam int NV = 33;
  localparam logic [13:0] TBL [0:NV-1] = '{
    {3'd1, 8'h00, 3'b000}, {3'd3, 8'h00, 3'b110}, {3'd4, 8'h06, 3'b110}, // R2 R4
    {3'd2, 8'h00, 3'b001}, {3'd0, 8'h00, 3'b000},                        // R7
    {3'd1, 8'h00, 3'b000}, {3'd3, 8'h01, 3'b100}, {3'd4, 8'h06, 3'b100}, // R3
    {3'd2, 8'h00, 3'b000},
    {3'd1, 8'h00, 3'b000}, {3'd3, 8'h00, 3'b110}, {3'd4, 8'h07, 3'b100}, // R5
    {3'd2, 8'h00, 3'b000},
    {3'd1, 8'h00, 3'b000}, {3'd3, 8'h00, 3'b110}, {3'd4, 8'h06, 3'b110}, // R6
    {3'd4, 8'h06, 3'b100}, {3'd2, 8'h00, 3'b000},
    {3'd1, 8'h00, 3'b000}, {3'd3, 8'h00, 3'b110}, {3'd4, 8'h06, 3'b110}, // R8
    {3'd1, 8'h00, 3'b000}, {3'd3, 8'h00, 3'b110}, {3'd4, 8'h06, 3'b110},
    {3'd2, 8'h00, 3'b001}, {3'd0, 8'h00, 3'b000},
    {3'd1, 8'h00, 3'b000}, {3'd3, 8'h40, 3'b100}, {3'd4, 8'h06, 3'b100}, // R3
    {3'd2, 8'h00, 3'b000},
    {3'd0, 8'h00, 3'b000}, {3'd3, 8'h00, 3'b100}, {3'd2, 8'h00, 3'b000}  // R9
  };

  logic clk = 1'b0;
  logic rst_n;
  logic start_i, stop_i, addr_v_i, data_v_i;
  logic [7:0] addr_i, data_i;
  logic ack_valid_o, ack_o, swrst_o;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gcr_swreset_det u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .addr_v_i(addr_v_i), .addr_i(addr_i), .data_v_i(data_v_i), .data_i(data_i),
    .ack_valid_o(ack_valid_o), .ack_o(ack_o), .swrst_o(swrst_o)
  );

  task automatic drive(input logic [2:0] kind, input logic [7:0] b);
    start_i  = (kind == 3'd1);
    stop_i   = (kind == 3'd2);
    addr_v_i = (kind == 3'd3);
    data_v_i = (kind == 3'd4);
    addr_i   = b;
    data_i   = b;
  endtask

  task automatic check(input string req, input logic [2:0] exp);
    checks++;
    if ({ack_valid_o, ack_o, swrst_o} !== exp) begin
      errors++;
      $display("FAIL %s: got ackv/ack/rst=%b expected %b", req,
               {ack_valid_o, ack_o, swrst_o}, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(3'd0, 8'h00);
    repeat (3) @(negedge clk);
    check("R1 in reset", 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 3'b000);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i][13:11], TBL[i][10:3]);
      @(negedge clk);
      check($sformatf("R2-table vector %0d", i), TBL[i][2:0]);
    end

    // R9: start wins over a strobe in the same cycle
    drive(3'd1, 8'h00); addr_v_i = 1'b1;
    @(negedge clk);
    check("R9 start with strobe", 3'b000);
    drive(3'd3, 8'h00);
    @(negedge clk);
    check("R9 address after start", 3'b110);
    // R9: stop wins over a data strobe
    drive(3'd4, 8'h06); stop_i = 1'b1;
    @(negedge clk);
    check("R9 stop with strobe", 3'b000);

    // R1: reset while armed cancels the pulse
    drive(3'd1, 8'h00); @(negedge clk);
    drive(3'd3, 8'h00); @(negedge clk);
    drive(3'd4, 8'h06); @(negedge clk);
    check("R4 armed before reset", 3'b110);
    drive(3'd0, 8'h00);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    drive(3'd2, 8'h00); @(negedge clk);
    check("R1 stop after reset", 3'b000);
    drive(3'd0, 8'h00); @(negedge clk);
    check("R10 idle no decision", 3'b000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule